// File: doc/BRIEF.md
# Leading-Zero Count Normalizer

This block left-justifies a data word and reports how many bit positions it moved the word. The shifter is logarithmic. A chain of 2:1 multiplexer layers shifts by half the word width, then a quarter, and so on down to one position. Each layer shifts only when the bits it would push out are all zero. The select bit of each layer is one bit of the count, so no separate priority encoder is needed.

A mode input picks how the word is read: as an unsigned number or as a two's-complement number. In signed mode a negative word is first negated into an unsigned magnitude. Its sign is reported on a separate output, and the magnitude is then normalized the same way as an unsigned word. An all-zero word cannot be told apart by the count alone, because the count saturates at its maximum. A separate zero flag reports that case.

An optional output register adds one cycle of latency and carries a valid bit. With the register disabled, the block is purely combinational.

Top module: `lzn_normalizer`

## Requirements
- R1: With in_valid high, the word on in_data is captured at a rising clock edge. After that edge, out_valid is 1 and the result is presented; with in_valid low at an edge, out_valid is 0 after that edge.
- R2: In unsigned mode (in_mode = 0), out_count equals the number of zero bits above the most significant 1 of in_data. This value runs from 0 to 15.
- R3: out_data equals the magnitude shifted left by out_count. The vacated low bits are zero. For a nonzero word, bit 15 of out_data is 1.
- R4: When the magnitude is zero, out_zero is 1, out_count is 15 and out_data is 0. Otherwise out_zero is 0.
- R5: In signed mode (in_mode = 1) with bit 15 of in_data set, the magnitude is the two's-complement negation of in_data, and out_neg is 1.
- R6: In signed mode the most negative word 0x8000 gives magnitude 0x8000, out_count 0, out_neg 1 and out_zero 0.
- R7: In signed mode, a word with bit 15 clear produces the same out_data, out_count and out_zero as unsigned mode, with out_neg 0.
- R8: In unsigned mode, out_neg is 0 for every input, including words with bit 15 set.
- R9: While rst_n is low, out_valid, out_data, out_count, out_zero and out_neg are all 0.
- R10: An edge with in_valid low leaves out_data, out_count, out_zero and out_neg unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is present this cycle |
| in_mode | input | 1 | 0 = unsigned, 1 = two's complement |
| in_data | input | 16 | Word to normalize |
| out_valid | output | 1 | Result registered from a valid input |
| out_data | output | 16 | Left-justified magnitude |
| out_count | output | 4 | Total left shift applied |
| out_zero | output | 1 | Magnitude was zero |
| out_neg | output | 1 | Signed input was negative |

## Verification
Every one of the 65536 unsigned words is compared with a reference that scans downward from the top bit. This separates a wrong layer select or a wrong fill at any shift amount from 0 to 15. Thousands of random signed words check the negation path and the sign output against unsigned handling of the same magnitude. A vector table pins the boundaries: zero in both modes, 0x8000 in both modes, minus one, and 0x7FFF. Directed steps cover the reset values and show that idle cycles leave the registered result untouched.

// File: rtl/lzn_pkg.sv
package lzn_pkg;

  typedef enum logic {
    LZN_UNSIGNED = 1'b0,
    LZN_SIGNED   = 1'b1
  } lzn_mode_e;

  // Number of shift layers needed to cover a word of the given width.
  function automatic int unsigned lzn_layers(input int unsigned width);
    int unsigned n;
    n = 0;
    while ((1 << n) < width) n++;
    return n;
  endfunction

endpackage

// File: rtl/lzn_magnitude.sv
module lzn_magnitude #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] in_data,
  input  logic             in_mode,
  output logic [WIDTH-1:0] mag,
  output logic             neg
);
  import lzn_pkg::*;

  // Negation in WIDTH bits; the most negative value maps onto itself.
  function automatic logic [WIDTH-1:0] negate(input logic [WIDTH-1:0] v);
    return WIDTH'(0) - v;
  endfunction

  always_comb begin
    neg = (in_mode == LZN_SIGNED) && in_data[WIDTH-1];
    mag = neg ? negate(in_data) : in_data;
  end

endmodule

// File: rtl/lzn_shift_layer.sv
module lzn_shift_layer #(
  parameter int WIDTH = 16,
  parameter int SHIFT = 8
) (
  input  logic [WIDTH-1:0] in_word,
  output logic [WIDTH-1:0] out_word,
  output logic             sel
);

  // Shift only when every bit that would leave the top is zero.
  always_comb begin
    sel      = (in_word[WIDTH-1 -: SHIFT] == '0);
    out_word = sel ? (in_word << SHIFT) : in_word;
  end

endmodule

// File: rtl/lzn_normalizer.sv
module lzn_normalizer #(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int CW     = lzn_pkg::lzn_layers(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_mode,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic [CW-1:0]    out_count,
  output logic             out_zero,
  output logic             out_neg
);

  logic [WIDTH-1:0]         mag;
  logic                     mag_neg;
  logic [CW:0][WIDTH-1:0]   stage;
  logic [CW-1:0]            layer_sel;
  logic                     res_zero;

  lzn_magnitude #(.WIDTH(WIDTH)) u_mag (
    .in_data (in_data),
    .in_mode (in_mode),
    .mag     (mag),
    .neg     (mag_neg)
  );

  assign stage[CW] = mag;

  // Layer gi shifts by 2**gi; the widest shift is applied first.
  for (genvar gi = 0; gi < CW; gi++) begin : g_layer
    lzn_shift_layer #(.WIDTH(WIDTH), .SHIFT(1 << gi)) u_layer (
      .in_word  (stage[gi+1]),
      .out_word (stage[gi]),
      .sel      (layer_sel[gi])
    );
  end

  // After full normalization a clear top bit can only mean a zero word.
  assign res_zero = ~stage[0][WIDTH-1];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        out_data  <= '0;
        out_count <= '0;
        out_zero  <= 1'b0;
        out_neg   <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          out_data  <= stage[0];
          out_count <= layer_sel;
          out_zero  <= res_zero;
          out_neg   <= mag_neg;
        end
      end
    end
  end else begin : g_comb
    always_comb begin
      out_valid = in_valid;
      out_data  = stage[0];
      out_count = layer_sel;
      out_zero  = res_zero;
      out_neg   = mag_neg;
    end
  end

endmodule

// File: rtl/lzn_checker.sv
module lzn_checker #(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int CW     = lzn_pkg::lzn_layers(WIDTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_mode,
  input logic [WIDTH-1:0] in_data,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_data,
  input logic [CW-1:0]    out_count,
  input logic             out_zero,
  input logic             out_neg
);
  import lzn_pkg::*;

  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  if (REG_OUT) begin : g_chk
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    // R1
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    // R3
    msb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_zero) |-> out_data[WIDTH-1]);
    // R3
    low_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_count != '0) |-> !out_data[0]);
    // R4
    zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_zero) |-> (out_data == '0 && out_count == '1));
    // R6
    most_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == LZN_SIGNED && in_data == MOST_NEG) |=>
        (out_count == '0 && out_neg && !out_zero && out_data == MOST_NEG));
    // R8
    unsigned_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == LZN_UNSIGNED) |=> !out_neg);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_data) && $stable(out_count) &&
                     $stable(out_zero) && $stable(out_neg)));
  end

endmodule

bind lzn_normalizer lzn_checker #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_lzn_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_mode   (in_mode),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_count (out_count),
  .out_zero  (out_zero),
  .out_neg   (out_neg)
);

// File: tb/tb_lzn_normalizer.sv
module tb_lzn_normalizer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int NVEC       = 12;
  localparam int NRAND      = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_mode = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;
  logic [3:0]  out_count;
  logic        out_zero;
  logic        out_neg;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  lzn_normalizer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_count(out_count), .out_zero(out_zero), .out_neg(out_neg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {mode, data, norm, count, zero, neg}
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b0, 16'h0001, 16'h8000, 4'd15, 1'b0, 1'b0},
    {1'b0, 16'h0000, 16'h0000, 4'd15, 1'b1, 1'b0},
    {1'b0, 16'h8000, 16'h8000, 4'd0,  1'b0, 1'b0},
    {1'b0, 16'h00F0, 16'hF000, 4'd8,  1'b0, 1'b0},
    {1'b0, 16'h0300, 16'hC000, 4'd6,  1'b0, 1'b0},
    {1'b0, 16'h1234, 16'h91A0, 4'd3,  1'b0, 1'b0},
    {1'b1, 16'hFFFF, 16'h8000, 4'd15, 1'b0, 1'b1},
    {1'b1, 16'h8000, 16'h8000, 4'd0,  1'b0, 1'b1},
    {1'b1, 16'h0000, 16'h0000, 4'd15, 1'b1, 1'b0},
    {1'b1, 16'hFF00, 16'h8000, 4'd7,  1'b0, 1'b1},
    {1'b1, 16'h7FFF, 16'hFFFE, 4'd1,  1'b0, 1'b0},
    {1'b1, 16'hFFF6, 16'hA000, 4'd12, 1'b0, 1'b1}
  };

  // Reference: scan down from the top bit, stop at the first one.
  function automatic logic [21:0] model(input logic mode, input logic [15:0] d);
    logic [15:0] m;
    logic        n;
    int          lz;
    n  = mode & d[15];
    m  = n ? (~d + 16'd1) : d;
    lz = 0;
    for (int b = 15; b >= 0; b--) begin
      if (m[b]) break;
      lz++;
    end
    if (lz == 16) return {16'h0000, 4'd15, 1'b1, n};
    return {m << lz, 4'(lz), 1'b0, n};
  endfunction

  task automatic check(input string req, input logic [21:0] exp);
    logic [21:0] act;
    act = {out_data, out_count, out_zero, out_neg};
    checks++;
    if (act !== exp || out_valid !== 1'b1) begin
      errors++;
      $display("FAIL %s: got data=%h cnt=%0d zero=%b neg=%b valid=%b expected data=%h cnt=%0d zero=%b neg=%b valid=1",
               req, act[21:6], act[5:2], act[1], act[0], out_valid,
               exp[21:6], exp[5:2], exp[1], exp[0]);
    end
  endtask

  // Drive at a falling edge, capture at the rising edge, inspect at the next falling edge.
  task automatic apply(input logic mode, input logic [15:0] d);
    in_valid = 1'b1;
    in_mode  = mode;
    in_data  = d;
    @(negedge clk);
  endtask

  initial begin
    logic [21:0] held;
    // R9: reset values
    in_data = 16'h1234;
    in_valid = 1'b1;
    #(CLK_PERIOD*3 + 1);
    checks++;
    if ({out_valid, out_data, out_count, out_zero, out_neg} !== '0) begin
      errors++;
      $display("FAIL R9: got %h expected 0",
               {out_valid, out_data, out_count, out_zero, out_neg});
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][38], VEC[i][37:22]);
      check("R2/R4/R5/R6/R7/R8 table", VEC[i][21:0]);
    end

    // R2 R3 R4: every unsigned word
    for (int v = 0; v < 65536; v++) begin
      apply(1'b0, 16'(v));
      check("R2 R3 exhaustive", model(1'b0, 16'(v)));
    end

    // R5 R7: random signed words
    for (int k = 0; k < NRAND; k++) begin
      logic [15:0] r;
      r = 16'($urandom);
      apply(1'b1, r);
      check("R5 R7 random", model(1'b1, r));
    end

    // R10: idle cycles with new data must not change the result
    apply(1'b1, 16'hFFF6);
    held = {out_data, out_count, out_zero, out_neg};
    in_valid = 1'b0;
    in_data  = 16'h0001;
    in_mode  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if ({out_data, out_count, out_zero, out_neg} !== held || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10: got %h valid=%b expected %h valid=0",
               {out_data, out_count, out_zero, out_neg}, out_valid, held);
    end

    // R1: valid returns one cycle after the next accepted word
    apply(1'b0, 16'h0040);
    check("R1 restart", model(1'b0, 16'h0040));

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule